// File: doc/BRIEF.md
# Bit-Serial Maximum Selector

The block finds which of several unsigned words is the largest when every word arrives as its own serial bit stream. All streams are clocked together, most significant bit first, one bit per stream per clock. A one-cycle start pulse opens a search. Each stream then has a survivor flag, and all flags are set by the start pulse. On each data cycle the block forms one shared signal, which is high when at least one surviving stream shows a 1. A surviving stream that shows a 0 while that shared signal is high loses its flag.

Once the last bit of the word has been taken in, a priority encoder converts the surviving flags into a stream index. The block then raises a one-cycle done strobe. If several streams hold the same largest value, the lowest-numbered one is reported. The index stays on the output until the next search completes. With the default sizes of 16 streams and 8-bit words, one result is produced every 9 clocks: one start cycle and eight data cycles.

Top module: `bitserial_max_select`

## Requirements
- R1: While `rst_n` is low and after its release, `done` is 0 and `max_idx` is 0 until a search completes.
- R2: The cycle in which `start` is sampled high marks every stream as a survivor. The values on `bits` during that cycle have no effect on the result.
- R3: On the `WORD_W` clock edges after the start edge, `bits[s]` carries bit `WORD_W-1-k` of word s at the k-th edge. After the last of these edges, `done` is 1 for exactly one cycle and `max_idx` equals the index of a stream whose word is the largest.
- R4: When several streams share the largest value, `max_idx` reports the lowest-numbered of them.
- R5: When all words are zero, every stream survives and `max_idx` is 0.
- R6: `max_idx` keeps its value while no search completes. `bits` values applied outside a search change neither `max_idx` nor `done`.
- R7: A `start` sampled during a search abandons it and begins a new search. The result then depends only on the bits that follow the new start.
- R8: A stream that has lost its flag never regains it within the search, even when its later bits are 1 (for example, 0111 loses to 1000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that opens a new search |
| bits | input | N_STREAMS | Current bit of each stream, MSB of the word first |
| max_idx | output | IDX_W | Index of the stream with the largest word |
| done | output | 1 | One-cycle strobe when `max_idx` is updated |

## Verification
The hardest case to reach is a stream that is eliminated early and then shows 1 bits in every later position. It must stay eliminated even though its later bits look like a winner's. Ties between streams are the other hard case, because only the lowest index may be reported. A bench configuration of four streams of three bits runs every combination of words (4096 searches). That sweep produces every ordering of eliminations and every tie. Directed sequences then add a start inside a search, and values on `bits` during the start cycle and between searches.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/bsm_seq_ctrl.sv
module bsm_seq_ctrl
    import bsm_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic step,
    output logic last
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(WORD_W - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = (st_q.ph == PH_RUN) && !start;
        last = step && (st_q.cnt == LAST_CNT);
        if (start) begin
            st_d.ph  = PH_RUN;
            st_d.cnt = '0;
        end else if (st_q.ph == PH_RUN) begin
            if (st_q.cnt == LAST_CNT) begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_CNT); // R3
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (st_q.ph == PH_IDLE)); // R3
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.ph == PH_RUN && st_q.cnt == '0)); // R7
endmodule

// File: rtl/bsm_hit_or.sv
module bsm_hit_or #(
    parameter int N_STREAMS = 16
) (
    input  logic [N_STREAMS-1:0] cand,
    input  logic [N_STREAMS-1:0] bits,
    output logic                 any_one
);
    logic [N_STREAMS-1:0] live_ones;

    always_comb begin
        live_ones = cand & bits;
        any_one   = |live_ones;
    end
endmodule

// File: rtl/bsm_cand_update.sv
module bsm_cand_update #(
    parameter int N_STREAMS = 16
) (
    input  logic [N_STREAMS-1:0] cand_cur,
    input  logic [N_STREAMS-1:0] bits,
    input  logic                 any_one,
    output logic [N_STREAMS-1:0] cand_nxt
);
    for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
        // keep the flag when the stream shows 1, or when no survivor shows 1
        assign cand_nxt[s] = cand_cur[s] & (bits[s] | ~any_one);
    end
endmodule

// File: rtl/bsm_prio_enc.sv
module bsm_prio_enc #(
    parameter int N_STREAMS = 16,
    parameter int IDX_W     = 4
) (
    input  logic [N_STREAMS-1:0] flags,
    output logic [IDX_W-1:0]     idx
);
    always_comb begin
        idx = '0;
        for (int i = N_STREAMS - 1; i >= 0; i--) begin
            if (flags[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/bitserial_max_select.sv
module bitserial_max_select
    import bsm_pkg::*;
#(
    parameter int N_STREAMS = 16,
    parameter int WORD_W    = 8,
    parameter int IDX_W     = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N_STREAMS-1:0] bits,
    output logic [IDX_W-1:0]     max_idx,
    output logic                 done
);
    typedef struct packed {
        logic [N_STREAMS-1:0] cand;
        logic [IDX_W-1:0]     idx;
        logic                 done;
    } core_t;

    core_t core_d, core_q;

    logic                 step;
    logic                 last;
    logic                 any_one;
    logic [N_STREAMS-1:0] cand_nxt;
    logic [IDX_W-1:0]     enc_idx;

    bsm_seq_ctrl #(.WORD_W(WORD_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .step  (step),
        .last  (last)
    );

    bsm_hit_or #(.N_STREAMS(N_STREAMS)) u_hit (
        .cand    (core_q.cand),
        .bits    (bits),
        .any_one (any_one)
    );

    bsm_cand_update #(.N_STREAMS(N_STREAMS)) u_upd (
        .cand_cur (core_q.cand),
        .bits     (bits),
        .any_one  (any_one),
        .cand_nxt (cand_nxt)
    );

    bsm_prio_enc #(.N_STREAMS(N_STREAMS), .IDX_W(IDX_W)) u_enc (
        .flags (cand_nxt),
        .idx   (enc_idx)
    );

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        if (start) begin
            core_d.cand = '1;
        end else if (step) begin
            core_d.cand = cand_nxt;
            if (last) begin
                core_d.idx  = enc_idx;
                core_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{cand: '0, idx: '0, done: 1'b0};
        end else begin
            core_q <= core_d;
        end
    end

    assign max_idx = core_q.idx;
    assign done    = core_q.done;

    logic [N_STREAMS-1:0] below_mask;
    always_comb begin
        for (int i = 0; i < N_STREAMS; i++) begin
            below_mask[i] = (i < int'(core_q.idx));
        end
    end

    AST_START_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (core_q.cand == '1)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_SOME_SURVIVE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (core_q.cand != '0)); // R3
    AST_WINNER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> core_q.cand[core_q.idx]); // R3
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((core_q.cand & below_mask) == '0)); // R4
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(max_idx)); // R6
    AST_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((core_q.cand & ~$past(core_q.cand)) == '0)); // R8
endmodule

// File: tb/bitserial_max_select_test.sv
module bitserial_max_select_test;
    localparam int N  = 4;
    localparam int W  = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  bits = '0;
    logic [IW-1:0] max_idx;
    logic          done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    int cycles   = 0;

    always #10 clk = ~clk;

    bitserial_max_select #(.N_STREAMS(N), .WORD_W(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .bits    (bits),
        .max_idx (max_idx),
        .done    (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expected_idx(input logic [W-1:0] v [N]);
        int best = 0;
        for (int s = 1; s < N; s++) begin
            if (v[s] > v[best]) best = s;
        end
        return best;
    endfunction

    function automatic logic [N-1:0] column(input logic [W-1:0] v [N], input int k);
        logic [N-1:0] c;
        for (int s = 0; s < N; s++) c[s] = v[s][W-1-k];
        return c;
    endfunction

    // one search: start cycle with junk on bits, W data cycles, result, one idle cycle
    task automatic run_word(input logic [W-1:0] v [N], input logic [N-1:0] junk, input string req);
        int exp = expected_idx(v);
        @(negedge clk);
        start = 1'b1;
        bits  = junk;                         // R2: ignored
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            start = 1'b0;
            bits  = column(v, k);
            check(done == 1'b0, "R3 early done", int'(done), 0);
        end
        @(negedge clk);
        bits = ~junk;
        check(done == 1'b1, "R3 done", int'(done), 1);
        check(int'(max_idx) == exp, req, int'(max_idx), exp);
        @(negedge clk);
        check(done == 1'b0, "R3 done width", int'(done), 0);
        check(int'(max_idx) == exp, "R6 hold", int'(max_idx), exp); // R6
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v [N];
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        check(max_idx == '0, "R1 idx in reset", int'(max_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        bits = '1;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(max_idx == '0, "R1 idx after reset", int'(max_idx), 0);

        // R5: all zero words
        for (int s = 0; s < N; s++) v[s] = '0;
        run_word(v, 4'b1010, "R5 all zero");

        // R8: early loser with trailing ones
        v[0] = 3'b011; v[1] = 3'b100; v[2] = 3'b011; v[3] = 3'b001;
        run_word(v, 4'b1111, "R8 no revive");

        // R4: tie at the top
        v[0] = 3'b010; v[1] = 3'b110; v[2] = 3'b001; v[3] = 3'b110;
        run_word(v, 4'b0101, "R4 tie lowest");

        // R6: idle cycles with bits toggling
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            bits = 4'(k * 5);
            check(done == 1'b0, "R6 idle done", int'(done), 0);
            check(int'(max_idx) == 1, "R6 idle idx", int'(max_idx), 1);
        end

        // R7: restart in the middle of a search
        @(negedge clk);
        start = 1'b1; bits = '0;
        @(negedge clk);
        start = 1'b0; bits = 4'b0001;         // would favour stream 0
        @(negedge clk);
        bits = 4'b0001;
        v[0] = 3'b000; v[1] = 3'b001; v[2] = 3'b111; v[3] = 3'b010;
        run_word(v, 4'b0001, "R7 restart");

        // R3, R4: exhaustive sweep over all word combinations
        for (int c = 0; c < (1 << (N * W)); c++) begin
            for (int s = 0; s < N; s++) v[s] = W'(c >> (W * s));
            run_word(v, 4'(c ^ 4'b0110), "R3 sweep");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule